// File: doc/BRIEF.md
# USB High-Speed Chirp Handshake FSM

This block sequences the transceiver control lines of a USB device port from power-up through attach, bus-reset recognition and the high-speed chirp handshake. It drives the operating mode, transceiver select, termination select, chirp enable and the two pull-down controls of a UTMI-style PHY. It watches the two-bit line state coming back from the PHY and counts time in ticks of an external timebase, so every millisecond-scale interval is a parameter that a simulation can shrink.

After a reset is recognised, the device drives its own chirp for a fixed number of ticks. It then listens for the host's alternating J/K chirps. Once enough distinct chirp transitions have been seen, it switches the PHY into high-speed termination. If the host never answers, a watchdog returns the port to full-speed. Each recognised bus reset raises a sticky flag that is cleared by writing a one. If the port keeps being reset without a detach in between, it drops off the bus for a while and then re-attaches.

Top module: `usb_hs_chirp_fsm`

## Requirements
In these requirements, "PHY word" means the 8-bit value {opmode_o[1:0], xcvrsel_o[1:0], termsel_o, chirp_en_o, dp_pulldown_o, dm_pulldown_o}. Line state codes are 0 = SE0, 1 = J, 2 = K and 3 = SE1.

- R1: While rst_ni is low and after reset, the PHY word is 0x40 (opmode 1, everything else 0) and bus_rst_flag_o is 0.
- R2: In the detached state, attach_i high moves the port to full-speed on the next edge, with PHY word 0x18 (opmode 0, xcvrsel 1, termsel 1).
- R3: In full-speed or high-speed, line state 0 held through SE0_TICKS ticks is a bus reset. The device chirp state follows on the next edge. A shorter SE0, broken by any other line state, has no effect.
- R4: bus_rst_flag_o is set by every recognised bus reset. It stays set until rst_flag_clr_i is high at a clock edge. If both happen in the same cycle, the set wins.
- R5: The device chirp state drives PHY word 0x8C (opmode 2, termsel 1, chirp_en 1) for CHIRP_TICKS ticks and leaves on the following edge. Cycles with tick_i low do not advance it.
- R6: After the device chirp, the listen state drives PHY word 0x88: chirp_en is dropped and the other chirp settings are kept.
- R7: In the listen state, a sample counts as a host chirp when it is 1 or 2 and differs from the previous sample. The first sample after entry is compared against code 3. A steady J or K therefore counts once, and codes 0 and 3 never count.
- R8: On the edge after the CHIRP_EDGES-th counted chirp, the PHY word becomes 0x00 (high-speed). High-speed keeps watching for bus resets as in R3.
- R9: If CHIRP_EDGES chirps are not counted within LISTEN_TICKS ticks of entering the listen state, the port returns to full-speed (0x18) on the next edge.
- R10: A bus reset that arrives when more than RST_RETRY resets have already been recognised since attach sends the port to a forced detach instead of a chirp. The forced detach shows PHY word 0x40 for DETACH_TICKS ticks, then returns to full-speed with the reset count cleared.
- R11: attach_i low gives PHY word 0x40 on the next edge from any state and clears the reset count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| attach_i | input | 1 | Request to connect to the bus |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| linestate_i | input | 2 | Line state from the PHY (0 SE0, 1 J, 2 K, 3 SE1) |
| rst_flag_clr_i | input | 1 | Write-one clear of the bus-reset flag |
| opmode_o | output | 2 | PHY operating mode |
| xcvrsel_o | output | 2 | PHY transceiver select |
| termsel_o | output | 1 | PHY termination select |
| chirp_en_o | output | 1 | Device chirp drive enable |
| dp_pulldown_o | output | 1 | D+ pull-down enable |
| dm_pulldown_o | output | 1 | D- pull-down enable |
| bus_rst_flag_o | output | 1 | Sticky bus-reset status |

## Verification
Every output comes straight from the state register, so each result is due on a counted edge:
- A bus reset shows on edge SE0_TICKS+1 of a held SE0.
- The device chirp lasts CHIRP_TICKS+1 edges when tick_i is high throughout.
- High-speed appears one edge after the edge that samples the fifth counted chirp.
- The watchdog and the forced detach fire LISTEN_TICKS+1 and DETACH_TICKS+1 edges after entry.
- Detach is one edge after attach_i falls.

The bench drives and samples on the falling clock edge and counts whole cycles to the edge before and the edge of each change. Where a wait length depends on earlier history, it first polls for the state change and then counts exact cycles from the edge where the change was seen.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

  typedef enum logic [2:0] {
    ST_DETACHED,
    ST_FS_IDLE,
    ST_DEV_CHIRP,
    ST_HOST_LISTEN,
    ST_HS_RUN,
    ST_FORCE_OFF
  } link_st_e;

  typedef struct packed {
    logic [1:0] opmode;
    logic [1:0] xcvr;
    logic       term;
    logic       chirp;
    logic       dp_pd;
    logic       dm_pd;
  } phy_ctl_t;

  localparam logic [1:0] LS_SE0 = 2'd0;
  localparam logic [1:0] LS_J   = 2'd1;
  localparam logic [1:0] LS_K   = 2'd2;
  localparam logic [1:0] LS_SE1 = 2'd3;

  function automatic phy_ctl_t phy_ctl_of(link_st_e st);
    phy_ctl_t c;
    c = '{opmode: 2'd1, xcvr: 2'd0, term: 1'b0, chirp: 1'b0, dp_pd: 1'b0, dm_pd: 1'b0};
    unique case (st)
      ST_FS_IDLE: begin
        c.opmode = 2'd0;
        c.xcvr   = 2'd1;
        c.term   = 1'b1;
      end
      ST_DEV_CHIRP: begin
        c.opmode = 2'd2;
        c.term   = 1'b1;
        c.chirp  = 1'b1;
      end
      ST_HOST_LISTEN: begin
        c.opmode = 2'd2;
        c.term   = 1'b1;
      end
      ST_HS_RUN: c.opmode = 2'd0;
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/usb_hs_tick_timer.sv
module usb_hs_tick_timer #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] limit_i,
  output logic             done_o
);

  logic [WIDTH-1:0] cnt_q;

  assign done_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/usb_hs_se0_det.sv
module usb_hs_se0_det
  import usb_hs_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic [1:0] ls_i,
  output logic       hit_o
);

  localparam int unsigned   CW     = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] HOLD_L = CW'(HOLD_TICKS);

  logic          se0;
  logic [CW-1:0] cnt_q;

  assign se0   = en_i && (ls_i == LS_SE0);
  assign hit_o = se0 && (cnt_q == HOLD_L);

  // any non-SE0 sample restarts the hold window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!se0)                        cnt_q <= '0;
    else if (tick_i && (cnt_q != HOLD_L)) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/usb_hs_chirp_cnt.sv
module usb_hs_chirp_cnt
  import usb_hs_pkg::*;
#(
  parameter int unsigned EDGES = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] ls_i,
  output logic       done_o
);

  localparam int unsigned   CW      = $clog2(EDGES + 1);
  localparam logic [CW-1:0] EDGES_L = CW'(EDGES);

  logic [1:0]    prev_q;
  logic [CW-1:0] cnt_q;
  logic          new_chirp;

  assign new_chirp = (ls_i != prev_q) && ((ls_i == LS_J) || (ls_i == LS_K));
  assign done_o    = (cnt_q == EDGES_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= LS_SE1;
      cnt_q  <= '0;
    end else if (!en_i) begin
      prev_q <= LS_SE1;
      cnt_q  <= '0;
    end else begin
      prev_q <= ls_i;
      if (new_chirp && !done_o) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/usb_hs_chirp_fsm.sv
module usb_hs_chirp_fsm
  import usb_hs_pkg::*;
#(
  parameter int unsigned SE0_TICKS    = 3,
  parameter int unsigned CHIRP_TICKS  = 3000,
  parameter int unsigned LISTEN_TICKS = 10000,
  parameter int unsigned DETACH_TICKS = 100000,
  parameter int unsigned CHIRP_EDGES  = 5,
  parameter int unsigned RST_RETRY    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       attach_i,
  input  logic       tick_i,
  input  logic [1:0] linestate_i,
  input  logic       rst_flag_clr_i,
  output logic [1:0] opmode_o,
  output logic [1:0] xcvrsel_o,
  output logic       termsel_o,
  output logic       chirp_en_o,
  output logic       dp_pulldown_o,
  output logic       dm_pulldown_o,
  output logic       bus_rst_flag_o
);

  localparam int unsigned MAX_CL = (CHIRP_TICKS > LISTEN_TICKS) ? CHIRP_TICKS : LISTEN_TICKS;
  localparam int unsigned MAX_T  = (MAX_CL > DETACH_TICKS) ? MAX_CL : DETACH_TICKS;
  localparam int unsigned TW     = $clog2(MAX_T + 1);
  localparam int unsigned RCW    = $clog2(RST_RETRY + 2);
  localparam logic [RCW-1:0] RETRY_L = RCW'(RST_RETRY);

  link_st_e       st_q, st_d;
  phy_ctl_t       phy;
  logic           mon_se0, se0_hit, rst_det;
  logic           edges_done, tmr_done, tmr_clr;
  logic [TW-1:0]  tmr_limit;
  logic [RCW-1:0] rst_cnt_q;
  logic           too_many;
  logic           flag_q;

  assign mon_se0  = (st_q == ST_FS_IDLE) || (st_q == ST_HS_RUN);
  assign rst_det  = se0_hit && attach_i;
  assign too_many = (rst_cnt_q > RETRY_L);

  usb_hs_se0_det #(.HOLD_TICKS(SE0_TICKS)) u_se0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mon_se0),
    .tick_i (tick_i),
    .ls_i   (linestate_i),
    .hit_o  (se0_hit)
  );

  usb_hs_chirp_cnt #(.EDGES(CHIRP_EDGES)) u_chirps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == ST_HOST_LISTEN),
    .ls_i   (linestate_i),
    .done_o (edges_done)
  );

  always_comb begin
    unique case (st_q)
      ST_DEV_CHIRP:   tmr_limit = TW'(CHIRP_TICKS);
      ST_HOST_LISTEN: tmr_limit = TW'(LISTEN_TICKS);
      ST_FORCE_OFF:   tmr_limit = TW'(DETACH_TICKS);
      default:        tmr_limit = '0;
    endcase
  end

  usb_hs_tick_timer #(.WIDTH(TW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .tick_i  (tick_i),
    .limit_i (tmr_limit),
    .done_o  (tmr_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DETACHED:    st_d = ST_FS_IDLE;
      ST_FS_IDLE,
      ST_HS_RUN:      if (rst_det) st_d = too_many ? ST_FORCE_OFF : ST_DEV_CHIRP;
      ST_DEV_CHIRP:   if (tmr_done) st_d = ST_HOST_LISTEN;
      ST_HOST_LISTEN: begin
        if (edges_done)    st_d = ST_HS_RUN;
        else if (tmr_done) st_d = ST_FS_IDLE;
      end
      ST_FORCE_OFF:   if (tmr_done) st_d = ST_FS_IDLE;
      default:        st_d = ST_DETACHED;
    endcase
    if (!attach_i) st_d = ST_DETACHED;
  end

  assign tmr_clr = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_DETACHED;
    else         st_q <= st_d;
  end

  // resets since attach; cleared on detach and on forced detach
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rst_cnt_q <= '0;
    else if (!attach_i) rst_cnt_q <= '0;
    else if (rst_det)  rst_cnt_q <= too_many ? '0 : rst_cnt_q + 1'b1;
  end

  // sticky, write-one-clear; set has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             flag_q <= 1'b0;
    else if (rst_det)        flag_q <= 1'b1;
    else if (rst_flag_clr_i) flag_q <= 1'b0;
  end

  assign phy            = phy_ctl_of(st_q);
  assign opmode_o       = phy.opmode;
  assign xcvrsel_o      = phy.xcvr;
  assign termsel_o      = phy.term;
  assign chirp_en_o     = phy.chirp;
  assign dp_pulldown_o  = phy.dp_pd;
  assign dm_pulldown_o  = phy.dm_pd;
  assign bus_rst_flag_o = flag_q;

endmodule

// File: rtl/usb_hs_chirp_fsm_chk.sv
module usb_hs_chirp_fsm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       attach_i,
  input logic       rst_flag_clr_i,
  input logic [1:0] opmode_o,
  input logic [1:0] xcvrsel_o,
  input logic       termsel_o,
  input logic       chirp_en_o,
  input logic       bus_rst_flag_o
);

  assert_chirp_cfg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chirp_en_o |-> (opmode_o == 2'd2 && xcvrsel_o == 2'd0 && termsel_o));

  assert_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_flag_o && !rst_flag_clr_i) |=> bus_rst_flag_o);

  assert_flag_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rst_flag_o) |-> (chirp_en_o || opmode_o == 2'd1));

  assert_listen_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opmode_o == 2'd2 && !chirp_en_o) |=> !chirp_en_o);

  assert_hs_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opmode_o == 2'd0 && xcvrsel_o == 2'd0 && $past(opmode_o) == 2'd2) |-> $past(!chirp_en_o));

  assert_detach_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !attach_i |=> (opmode_o == 2'd1 && !termsel_o && !chirp_en_o));

endmodule

bind usb_hs_chirp_fsm usb_hs_chirp_fsm_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .attach_i       (attach_i),
  .rst_flag_clr_i (rst_flag_clr_i),
  .opmode_o       (opmode_o),
  .xcvrsel_o      (xcvrsel_o),
  .termsel_o      (termsel_o),
  .chirp_en_o     (chirp_en_o),
  .bus_rst_flag_o (bus_rst_flag_o)
);

// File: tb/tb_usb_hs_chirp_fsm.sv
`timescale 1ns/1ps
module tb_usb_hs_chirp_fsm;

  localparam int unsigned SE0_T    = 4;
  localparam int unsigned CHIRP_T  = 6;
  localparam int unsigned LISTEN_T = 40;
  localparam int unsigned DETACH_T = 30;

  localparam logic [7:0] P_DET    = 8'h40;
  localparam logic [7:0] P_FS     = 8'h18;
  localparam logic [7:0] P_CHIRP  = 8'h8C;
  localparam logic [7:0] P_LISTEN = 8'h88;
  localparam logic [7:0] P_HS     = 8'h00;

  // {reach_hs, s0..s7}, s0 in the top pair
  localparam logic [16:0] VEC [0:7] = '{
    {1'b1, 2'd2,2'd1,2'd2,2'd1,2'd2,2'd1,2'd2,2'd1},
    {1'b0, 2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2},
    {1'b0, 2'd2,2'd1,2'd2,2'd1,2'd0,2'd0,2'd0,2'd0},
    {1'b0, 2'd2,2'd0,2'd2,2'd0,2'd2,2'd0,2'd2,2'd0},
    {1'b1, 2'd1,2'd0,2'd2,2'd0,2'd1,2'd0,2'd2,2'd1},
    {1'b0, 2'd3,2'd1,2'd3,2'd2,2'd3,2'd1,2'd3,2'd2},
    {1'b1, 2'd2,2'd1,2'd1,2'd2,2'd2,2'd1,2'd1,2'd2},
    {1'b0, 2'd1,2'd1,2'd1,2'd1,2'd2,2'd2,2'd2,2'd2}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       attach_i = 1'b0;
  logic       tick_i = 1'b1;
  logic [1:0] linestate_i = 2'd1;
  logic       rst_flag_clr_i = 1'b0;
  logic [1:0] opmode_o, xcvrsel_o;
  logic       termsel_o, chirp_en_o, dp_pulldown_o, dm_pulldown_o, bus_rst_flag_o;
  logic [7:0] phy;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk_i = ~clk_i;

  usb_hs_chirp_fsm #(
    .SE0_TICKS(SE0_T), .CHIRP_TICKS(CHIRP_T), .LISTEN_TICKS(LISTEN_T),
    .DETACH_TICKS(DETACH_T), .CHIRP_EDGES(5), .RST_RETRY(4)
  ) dut (
    .clk_i, .rst_ni, .attach_i, .tick_i, .linestate_i, .rst_flag_clr_i,
    .opmode_o, .xcvrsel_o, .termsel_o, .chirp_en_o,
    .dp_pulldown_o, .dm_pulldown_o, .bus_rst_flag_o
  );

  assign phy = {opmode_o, xcvrsel_o, termsel_o, chirp_en_o, dp_pulldown_o, dm_pulldown_o};

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk_phy(input logic [7:0] exp, input string tag);
    total++;
    if (phy !== exp) begin
      bad++;
      $display("FAIL %s phy=%h expected=%h", tag, phy, exp);
    end
  endtask

  task automatic chk_flag(input logic exp, input string tag);
    total++;
    if (bus_rst_flag_o !== exp) begin
      bad++;
      $display("FAIL %s flag=%0b expected=%0b", tag, bus_rst_flag_o, exp);
    end
  endtask

  task automatic wait_phy(input logic [7:0] exp, input int lim, input string tag);
    for (int k = 0; k < lim && phy !== exp; k++) cyc(1);
    chk_phy(exp, tag);
  endtask

  task automatic pulse_clr();
    rst_flag_clr_i = 1'b1;
    cyc(1);
    rst_flag_clr_i = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    chk_phy(P_DET, "R1 reset phy");
    chk_flag(1'b0, "R1 reset flag");
    rst_ni = 1'b1;
    cyc(2);
    chk_phy(P_DET, "R1 idle after reset");

    attach_i = 1'b1;
    cyc(1);
    chk_phy(P_FS, "R2 attach to full-speed");

    // short SE0: broken one tick before recognition
    linestate_i = 2'd0;
    cyc(SE0_T);
    linestate_i = 2'd1;
    cyc(3);
    chk_phy(P_FS, "R3 short SE0 ignored");
    chk_flag(1'b0, "R3 short SE0 no flag");

    linestate_i = 2'd0;
    cyc(SE0_T);
    chk_phy(P_FS, "R3 edge before reset");
    cyc(1);
    chk_phy(P_CHIRP, "R3 reset recognised");
    chk_flag(1'b1, "R4 flag set");

    cyc(CHIRP_T);
    chk_phy(P_CHIRP, "R5 chirp still held");
    cyc(1);
    chk_phy(P_LISTEN, "R6 listen phase");

    cyc(LISTEN_T);
    chk_phy(P_LISTEN, "R9 edge before watchdog");
    cyc(1);
    chk_phy(P_FS, "R9 watchdog to full-speed");
    linestate_i = 2'd1;

    chk_flag(1'b1, "R4 flag sticky");
    pulse_clr();
    chk_flag(1'b0, "R4 flag cleared");

    // tick gating and detach from chirp
    linestate_i = 2'd0;
    wait_phy(P_CHIRP, 20, "R5 second chirp");
    tick_i = 1'b0;
    cyc(20);
    chk_phy(P_CHIRP, "R5 no tick holds chirp");
    attach_i = 1'b0;
    cyc(1);
    chk_phy(P_DET, "R11 detach during chirp");
    tick_i = 1'b1;
    linestate_i = 2'd1;
    cyc(2);

    for (int v = 0; v < 8; v++) begin
      attach_i = 1'b1;
      linestate_i = 2'd1;
      cyc(2);
      linestate_i = 2'd0;
      wait_phy(P_CHIRP, 20, "R7 vector chirp");
      wait_phy(P_LISTEN, 20, "R7 vector listen");
      for (int j = 0; j < 8; j++) begin
        linestate_i = VEC[v][15-2*j -: 2];
        cyc(1);
      end
      cyc(1);
      chk_phy(VEC[v][16] ? P_HS : P_LISTEN, $sformatf("R7 R8 vector %0d", v));
      attach_i = 1'b0;
      linestate_i = 2'd1;
      cyc(2);
    end

    // reset from high-speed
    attach_i = 1'b1;
    cyc(2);
    linestate_i = 2'd0;
    wait_phy(P_CHIRP, 20, "R8 chirp before hs");
    wait_phy(P_LISTEN, 20, "R8 listen before hs");
    for (int j = 0; j < 5; j++) begin
      linestate_i = (j % 2 == 0) ? 2'd2 : 2'd1;
      cyc(1);
    end
    chk_phy(P_LISTEN, "R8 edge before hs");
    cyc(1);
    chk_phy(P_HS, "R8 high-speed entered");
    pulse_clr();
    chk_flag(1'b0, "R4 clear in hs");
    linestate_i = 2'd0;
    cyc(SE0_T);
    chk_phy(P_HS, "R8 hs before reset");
    cyc(1);
    chk_phy(P_CHIRP, "R8 reset from hs");
    chk_flag(1'b1, "R4 flag from hs reset");
    attach_i = 1'b0;
    cyc(2);

    // repeated resets
    attach_i = 1'b1;
    linestate_i = 2'd0;
    for (int k = 1; k <= 5; k++) begin
      wait_phy(P_CHIRP, 40, $sformatf("R10 reset %0d chirps", k));
      wait_phy(P_FS, 200, $sformatf("R10 reset %0d back to fs", k));
    end
    wait_phy(P_DET, 40, "R10 sixth reset forces detach");
    linestate_i = 2'd1;
    cyc(DETACH_T);
    chk_phy(P_DET, "R10 detach held");
    cyc(1);
    chk_phy(P_FS, "R10 re-attach");
    linestate_i = 2'd0;
    wait_phy(P_CHIRP, 40, "R10 count restarted");

    summary();
    $finish;
  end

endmodule